// File: doc/BRIEF.md
# Push-Button Power Sequencing Controller

This block is a synchronous state machine that starts a set of voltage regulators in a fixed order and keeps them on. The system starts from off when the active-low push-button input goes low. The core rail is enabled first and alone. When its power-good input becomes true, a millisecond counter starts. Two further rails come up at fixed tick counts on that counter. The processor reset output is released once a longer reset window has elapsed with power-good still present. From then on the system is "on", and four auxiliary rails follow a separate enable input.

The processor must raise its hold input while it boots. Without hold, releasing the button drops every rail. While the system is on, a button press drives an active-low interrupt output to the processor and does not switch anything off. Shutdown is left to software, which writes a 1 to a single master-off bit. That bit clears itself when the block reaches the off state. All timing counts pulses of a one-cycle millisecond strobe supplied from outside. Every input is assumed to be synchronous to `clk`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, and whenever the block is off, `rail_en` is 0, `cpu_rst_n` is low and `btn_irq_n` is high. A low on `button_n` while off starts power-up, and at that point only the core rail, `rail_en` bit 2, is set.
- R2: Once `core_pgood` is true during power-up, the reset counter runs and `cpu_rst_n` stays low while it counts.
- R3: `rail_en` bit 0 is set once `D1_MS` ticks (default 2) have been counted with power-good true. `rail_en` bit 1 is set once `D2_MS` ticks (default 4) have been counted.
- R4: `cpu_rst_n` goes high after `RST_MS` ticks (default 40) of continuous power-good. This completes the power-up.
- R5: Outside the off state, the block stays powered only while `button_n` is low or `proc_hold` is high. If neither holds, the block returns to off.
- R6: `rail_en` bits 3 to 6 equal `aux_enable`, but only after power-up is complete. Before that they stay 0 whatever `aux_enable` is.
- R7: While the system is on, `btn_irq_n` is low for as long as `button_n` is low, and the rails do not change. While off or powering up, `btn_irq_n` stays high.
- R8: A cycle with `mstr_off_we` high and `mstr_off_wdata` at 1 switches the block off and clears every rail enable. A write of 0 has no effect.
- R9: If `core_pgood` drops before power-up completes, the block returns to off and `cpu_rst_n` stays low.
- R10: The master-off bit clears itself on entry to off, so the next button press powers up normally.
- R11: A master-off write that arrives in the same cycle as the final reset tick wins. The block goes off and `cpu_rst_n` is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| button_n | input | 1 | Push-button, low when pressed |
| core_pgood | input | 1 | Core rail power-good |
| proc_hold | input | 1 | Processor keep-alive hold |
| aux_enable | input | 1 | Enable for the auxiliary rails |
| mstr_off_we | input | 1 | Write strobe for the master-off bit |
| mstr_off_wdata | input | 1 | Value written to the master-off bit |
| rail_en | output | 7 | Rail enables: bit n drives regulator n+1, bit 2 is the core rail |
| cpu_rst_n | output | 1 | Processor reset, low while asserted |
| btn_irq_n | output | 1 | Button-status interrupt, low while active |

## Verification
Two events can land in the same clock edge: the reset counter reaching its limit, and a software shutdown request. The bench drives the last millisecond tick and a master-off write of 1 on the same clock edge. It then watches `cpu_rst_n` for several cycles and must never see it go high. It also requires that all rails end up cleared. A second overlap is tested as well: a button press while the system is on. It must raise the interrupt and leave every rail enable exactly as it was.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_RAMP = 2'd1,
    PS_HOLD = 2'd2,
    PS_ON   = 2'd3
  } pwr_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return m;
  endfunction

endpackage

// File: rtl/psc_tick_timer.sv
module psc_tick_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/psc_master_off.sv
module psc_master_off (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_data,
  input  logic clear,
  output logic mstr_off
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mstr_off <= 1'b0;
    end else if (wr_en && wr_data) begin
      mstr_off <= 1'b1;
    end
  end

  // R10: self-clear once the off state is reached
  a_r10_self_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> !mstr_off);

endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
  import pwr_seq_pkg::*;
#(
  parameter int CW     = 6,
  parameter int RST_MS = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          button_n,
  input  logic          core_pgood,
  input  logic          proc_hold,
  input  logic          mstr_off,
  input  logic [CW-1:0] cnt,
  output pwr_state_e    state
);

  localparam logic [CW-1:0] RST_C = CW'(RST_MS);

  pwr_state_e state_nxt;
  logic       keep_alive;

  assign keep_alive = !button_n || proc_hold;

  always_comb begin
    state_nxt = state;
    unique case (state)
      PS_OFF: begin
        if (!button_n) state_nxt = PS_RAMP;
      end
      PS_RAMP: begin
        if (mstr_off || !keep_alive) state_nxt = PS_OFF;
        else if (core_pgood)         state_nxt = PS_HOLD;
      end
      PS_HOLD: begin
        if (mstr_off || !keep_alive || !core_pgood) state_nxt = PS_OFF;
        else if (cnt >= RST_C)                      state_nxt = PS_ON;
      end
      PS_ON: begin
        if (mstr_off || !keep_alive) state_nxt = PS_OFF;
      end
      default: state_nxt = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PS_OFF;
    else     state <= state_nxt;
  end

  // R8: a pending master-off ends the on state
  a_r8_mstr_off_ends_on: assert property (@(posedge clk) disable iff (rst)
    (state == PS_ON && mstr_off) |=> state == PS_OFF);

  // R9: losing power-good during the reset window returns to off
  a_r9_pgood_drop: assert property (@(posedge clk) disable iff (rst)
    (state == PS_HOLD && !core_pgood) |=> state == PS_OFF);

  // R5: without button or hold the block cannot stay up
  a_r5_keep_alive: assert property (@(posedge clk) disable iff (rst)
    (state != PS_OFF && button_n && !proc_hold) |=> state == PS_OFF);

  // R1: power-up leaves off only through the ramp state
  a_r1_start_ramp: assert property (@(posedge clk) disable iff (rst)
    (state == PS_OFF) |=> (state == PS_OFF || state == PS_RAMP));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int D1_MS  = 2,
  parameter int D2_MS  = 4,
  parameter int RST_MS = 40,
  parameter int N_AUX  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             button_n,
  input  logic             core_pgood,
  input  logic             proc_hold,
  input  logic             aux_enable,
  input  logic             mstr_off_we,
  input  logic             mstr_off_wdata,
  output logic [N_AUX+2:0] rail_en,
  output logic             cpu_rst_n,
  output logic             btn_irq_n
);

  localparam int MAX_MS = max3(D1_MS, D2_MS, RST_MS);
  localparam int CW     = (MAX_MS < 1) ? 1 : $clog2(MAX_MS + 1);
  localparam logic [CW-1:0] D1_C = CW'(D1_MS);
  localparam logic [CW-1:0] D2_C = CW'(D2_MS);
  localparam int NR = N_AUX + 3;

  pwr_state_e    state;
  logic [CW-1:0] cnt;
  logic          mstr_off;
  logic [NR-1:0] rail_nxt;

  psc_tick_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (state != PS_HOLD),
    .tick  (ms_tick),
    .cnt   (cnt)
  );

  psc_master_off u_moff (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (mstr_off_we),
    .wr_data  (mstr_off_wdata),
    .clear    (state == PS_OFF),
    .mstr_off (mstr_off)
  );

  psc_fsm #(.CW(CW), .RST_MS(RST_MS)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .button_n   (button_n),
    .core_pgood (core_pgood),
    .proc_hold  (proc_hold),
    .mstr_off   (mstr_off),
    .cnt        (cnt),
    .state      (state)
  );

  always_comb begin
    rail_nxt    = '0;
    rail_nxt[2] = (state != PS_OFF);
    rail_nxt[0] = (state == PS_ON) || (state == PS_HOLD && cnt >= D1_C);
    rail_nxt[1] = (state == PS_ON) || (state == PS_HOLD && cnt >= D2_C);
  end

  generate
    for (genvar g = 0; g < N_AUX; g++) begin : g_aux
      always_ff @(posedge clk) begin
        if (rst) rail_en[3+g] <= 1'b0;
        else     rail_en[3+g] <= (state == PS_ON) && aux_enable;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_en[2:0] <= '0;
      cpu_rst_n    <= 1'b0;
      btn_irq_n    <= 1'b1;
    end else begin
      rail_en[2:0] <= rail_nxt[2:0];
      cpu_rst_n    <= (state == PS_ON);
      btn_irq_n    <= !((state == PS_ON) && !button_n);
    end
  end

  // R3: staged rails never come up without the core rail
  a_r3_core_first: assert property (@(posedge clk) disable iff (rst)
    (rail_en[0] || rail_en[1]) |-> rail_en[2]);

  // R4: reset release implies all main rails are up
  a_r4_rst_with_rails: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_n |-> (rail_en[2:0] == 3'b111));

  // R6: auxiliary rails only once power-up has completed
  a_r6_aux_after_boot: assert property (@(posedge clk) disable iff (rst)
    (|rail_en[NR-1:3]) |-> cpu_rst_n);

  // R7: interrupt only while the system is on
  a_r7_irq_when_on: assert property (@(posedge clk) disable iff (rst)
    !btn_irq_n |-> rail_en[2]);

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b0;
  logic       button_n = 1'b1;
  logic       core_pgood = 1'b0;
  logic       proc_hold = 1'b0;
  logic       aux_enable = 1'b0;
  logic       mstr_off_we = 1'b0;
  logic       mstr_off_wdata = 1'b0;
  logic [6:0] rail_en;
  logic       cpu_rst_n;
  logic       btn_irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk            (clk),
    .rst            (rst),
    .ms_tick        (ms_tick),
    .button_n       (button_n),
    .core_pgood     (core_pgood),
    .proc_hold      (proc_hold),
    .aux_enable     (aux_enable),
    .mstr_off_we    (mstr_off_we),
    .mstr_off_wdata (mstr_off_wdata),
    .rail_en        (rail_en),
    .cpu_rst_n      (cpu_rst_n),
    .btn_irq_n      (btn_irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    cyc(1);
    ms_tick = 1'b0;
    cyc(2);
  endtask

  task automatic all_idle();
    button_n = 1'b1; core_pgood = 1'b0; proc_hold = 1'b0; aux_enable = 1'b0;
    cyc(4);
  endtask

  task automatic t_reset();
    check("R1 rails after reset", rail_en, 0);
    check("R1 cpu_rst_n after reset", cpu_rst_n, 0);
    check("R1 btn_irq_n after reset", btn_irq_n, 1);
  endtask

  task automatic t_powerup();
    button_n = 1'b0;
    cyc(3);
    check("R1 core rail alone", rail_en, 7'b0000100);
    check("R7 no irq during power-up", btn_irq_n, 1);
    core_pgood = 1'b1;
    cyc(3);
    proc_hold = 1'b1;
    tick();
    check("R3 rail1 not at 1 tick", rail_en, 7'b0000100);
    tick();
    check("R3 rail1 at 2 ticks", rail_en, 7'b0000101);
    tick();
    check("R3 rail2 not at 3 ticks", rail_en, 7'b0000101);
    tick();
    check("R3 rail2 at 4 ticks", rail_en, 7'b0000111);
    aux_enable = 1'b1;
    cyc(2);
    check("R6 aux held off before boot", rail_en, 7'b0000111);
    repeat (35) tick();
    check("R2 reset held at 39 ticks", cpu_rst_n, 0);
    check("R7 no irq before on", btn_irq_n, 1);
    tick();
    check("R4 reset released at 40 ticks", cpu_rst_n, 1);
    check("R6 aux on after boot", rail_en, 7'b1111111);
    button_n = 1'b1;
    cyc(3);
    check("R5 hold keeps rails after release", rail_en, 7'b1111111);
    aux_enable = 1'b0;
    cyc(2);
    check("R6 aux follows enable", rail_en, 7'b0000111);
  endtask

  task automatic t_irq();
    button_n = 1'b0;
    cyc(2);
    check("R7 irq low on press", btn_irq_n, 0);
    check("R7 rails unchanged on press", rail_en, 7'b0000111);
    cyc(5);
    check("R7 irq still low while held", btn_irq_n, 0);
    button_n = 1'b1;
    cyc(2);
    check("R7 irq high on release", btn_irq_n, 1);
  endtask

  task automatic t_mstr_write0();
    mstr_off_we = 1'b1; mstr_off_wdata = 1'b0;
    cyc(1);
    mstr_off_we = 1'b0;
    cyc(4);
    check("R8 write of 0 ignored", cpu_rst_n, 1);
    check("R8 rails kept after write 0", rail_en, 7'b0000111);
  endtask

  task automatic t_mstr_off();
    mstr_off_we = 1'b1; mstr_off_wdata = 1'b1;
    cyc(1);
    mstr_off_we = 1'b0; mstr_off_wdata = 1'b0;
    cyc(3);
    check("R8 rails cleared by master-off", rail_en, 0);
    check("R8 reset asserted by master-off", cpu_rst_n, 0);
    all_idle();
  endtask

  task automatic t_selfclear_pgdrop();
    button_n = 1'b0;
    cyc(3);
    check("R10 core on after master-off cycle", rail_en, 7'b0000100);
    core_pgood = 1'b1;
    cyc(3);
    check("R10 still up with power-good", rail_en, 7'b0000100);
    proc_hold = 1'b1;
    button_n = 1'b1;
    cyc(2);
    tick();
    core_pgood = 1'b0;
    cyc(3);
    check("R9 rails off on power-good drop", rail_en, 0);
    check("R9 reset kept low", cpu_rst_n, 0);
    all_idle();
  endtask

  task automatic t_no_hold();
    button_n = 1'b0;
    cyc(3);
    core_pgood = 1'b1;
    cyc(3);
    button_n = 1'b1;
    cyc(3);
    check("R5 no hold drops rails", rail_en, 0);
    all_idle();
  endtask

  task automatic t_coincide();
    int rose;
    rose = 0;
    button_n = 1'b0;
    cyc(3);
    core_pgood = 1'b1;
    proc_hold = 1'b1;
    cyc(3);
    button_n = 1'b1;
    repeat (39) tick();
    ms_tick = 1'b1; mstr_off_we = 1'b1; mstr_off_wdata = 1'b1;
    cyc(1);
    ms_tick = 1'b0; mstr_off_we = 1'b0; mstr_off_wdata = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (cpu_rst_n) rose = 1;
      cyc(1);
    end
    check("R11 reset never released", rose, 0);
    check("R11 rails cleared", rail_en, 0);
    all_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_powerup();
    t_irq();
    t_mstr_write0();
    t_mstr_off();
    t_selfclear_pgdrop();
    t_no_hold();
    t_coincide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule